// File: doc/BRIEF.md
# Boot Reset Sequencer

The sequencer decides when a synchronous processor core may leave reset and when it may start fetching. It watches an active-low external hard reset, a power-good level and a clock-stable (PLL lock) level. It lets the core out of reset only while all three are healthy. It then hands the core to built-in self-test, and finally raises a run enable with a boot address of zero. Each of the three asynchronous levels passes through a two-flop synchroniser. Every output is decoded from registered state, so all changes follow the rising clock edge.

Two sticky flags record the self-test outcome: one for pass and one for fail. While the pass flag is set, a later warm reset (external reset pulse or a lock glitch) goes straight to execution without repeating self-test. A failed self-test halts the sequencer with the core held in reset. Both flags are cleared only by a power-up event: the asynchronous power-on reset input, or a loss of power-good. A small clock-status word reports whether a PLL is fitted, whether it is locked, and that the external full-speed source is selected. This is always the case after any reset. When no PLL is fitted, the word is a fixed value.

Top module: `boot_seq`

## Requirements
- R1: `por_n` low clears every register at once. While the synchronised external reset is low, `rst_core_n` is 0. A low on `ext_rst_n` before an edge forces `rst_core_n` to 0 after the third rising edge.
- R2: `rst_core_n` goes to 1 only when synchronised external reset, power-good and lock are all high. It rises after the third rising edge following the cycle in which all three inputs became high.
- R3: A loss of power-good, lock or external reset in any state returns the sequencer to reset hold. `rst_core_n` and `run_en` are 0 after the third edge.
- R4: With the pass flag clear, `bist_start` is a single-cycle pulse in the cycle after the one in which `rst_core_n` first reads 1.
- R5: When `bist_done` and `bist_pass` are both 1 at an edge while self-test is awaited, `run_en` and `bist_ok_flag` are 1 from that edge on. `bist_done` outside the self-test wait has no effect.
- R6: With `bist_ok_flag` set, a reset release produces no `bist_start`, and `run_en` rises one cycle after `rst_core_n` rises.
- R7: `bist_done` with `bist_pass` 0 while self-test is awaited sets `bist_fail_flag`. It halts with `run_en` 0 and `rst_core_n` 0, and an external reset pulse does not leave that halt.
- R8: The flags are cleared only by `por_n` low or by a synchronised power-good low. A lock loss or an external reset keeps them.
- R9: `boot_addr` is all zeros.
- R10: Encoding of `clk_status`: bit 0 is PLL fitted, bit 1 is synchronised lock (0 when not fitted), bit 2 is 1 for the external full-speed source, and bits 7:3 are 0. With `HAS_PLL`=0 the word is constantly 8'h04, and `pll_lock` is treated as always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External hard reset, active low, asynchronous |
| pwr_good | input | 1 | Supply stable level, asynchronous |
| pll_lock | input | 1 | Clock-stable level, asynchronous |
| bist_done | input | 1 | Self-test finished strobe |
| bist_pass | input | 1 | Self-test verdict, valid with `bist_done` |
| rst_core_n | output | 1 | Core reset, active low |
| bist_start | output | 1 | Self-test launch pulse |
| run_en | output | 1 | Core execution enable |
| boot_addr | output | ADDR_W | First fetch address |
| clk_status | output | 8 | Clock-status word |
| bist_ok_flag | output | 1 | Sticky self-test pass |
| bist_fail_flag | output | 1 | Sticky self-test fail |

## Verification
The stimulus brings up supply, external reset and lock in different orders. A late lock separates gating by the lock input from gating by power-good alone, and a fitted and an unfitted PLL instance run side by side to tell them apart. The warm-reset patterns are an external reset pulse and a lock glitch after a pass, and they show whether the skip path is taken. A power-good dip shows that the flags are cleared. A failing verdict followed by an external reset shows that the halt holds until power is lost. A completion strobe raised during normal running shows whether the verdict is sampled only while self-test is awaited.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    SQ_HOLD   = 3'd0,
    SQ_REL    = 3'd1,
    SQ_BSTART = 3'd2,
    SQ_BWAIT  = 3'd3,
    SQ_RUN    = 3'd4,
    SQ_HALT   = 3'd5
  } seq_state_t;

  localparam int STAT_W = 8;

  // all three qualifiers must be high before the core may leave reset
  function automatic logic seq_ready(input logic ext_hi, input logic pg, input logic lk);
    return ext_hi & pg & lk;
  endfunction

  // core reset is released in every state of the start-up path
  function automatic logic core_released(input seq_state_t s);
    return (s == SQ_REL) || (s == SQ_BSTART) || (s == SQ_BWAIT) || (s == SQ_RUN);
  endfunction

  // bit0 fitted, bit1 locked, bit2 external full-speed source selected
  function automatic logic [STAT_W-1:0] clk_stat_word(input logic present, input logic lock);
    return {5'b00000, 1'b1, lock & present, present};
  endfunction

endpackage

// File: rtl/boot_seq_sync.sv
module boot_seq_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       ready,
  input  logic       pg_s,
  input  logic       bist_done,
  input  logic       bist_pass,
  output seq_state_t state,
  output logic       ok_flag,
  output logic       fail_flag
);
  seq_state_t nxt;
  logic       verdict;

  assign verdict = ready && (state == SQ_BWAIT) && bist_done;

  always_comb begin
    nxt = state;
    if (!ready) begin
      nxt = SQ_HOLD;
    end else begin
      unique case (state)
        SQ_HOLD:   nxt = fail_flag ? SQ_HALT : SQ_REL;
        SQ_REL:    nxt = ok_flag ? SQ_RUN : SQ_BSTART;
        SQ_BSTART: nxt = SQ_BWAIT;
        SQ_BWAIT:  if (bist_done) nxt = bist_pass ? SQ_RUN : SQ_HALT;
        SQ_RUN:    nxt = SQ_RUN;
        SQ_HALT:   nxt = SQ_HALT;
        default:   nxt = SQ_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state <= SQ_HOLD;
    else         state <= nxt;
  end

  // flags survive warm resets; a supply drop counts as a power-up
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ok_flag   <= 1'b0;
      fail_flag <= 1'b0;
    end else if (!pg_s) begin
      ok_flag   <= 1'b0;
      fail_flag <= 1'b0;
    end else if (verdict) begin
      if (bist_pass) ok_flag   <= 1'b1;
      else           fail_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_seq_stat.sv
module boot_seq_stat
  import boot_seq_pkg::*;
#(
  parameter bit HAS_PLL = 1'b1
) (
  input  logic              lock_s,
  output logic [STAT_W-1:0] clk_status
);
  localparam logic PRESENT = HAS_PLL;

  assign clk_status = clk_stat_word(PRESENT, lock_s);
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter bit HAS_PLL     = 1'b1,
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              pwr_good,
  input  logic              pll_lock,
  input  logic              bist_done,
  input  logic              bist_pass,
  output logic              rst_core_n,
  output logic              bist_start,
  output logic              run_en,
  output logic [ADDR_W-1:0] boot_addr,
  output logic [STAT_W-1:0] clk_status,
  output logic              bist_ok_flag,
  output logic              bist_fail_flag
);
  localparam int NSYNC = 3;

  logic       ext_s, pg_s, lk_raw_s, lk_s, rdy_w;
  seq_state_t state;

  boot_seq_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      ({ext_rst_n, pwr_good, pll_lock}),
    .q      ({ext_s, pg_s, lk_raw_s})
  );

  generate
    if (HAS_PLL) begin : g_pll
      assign lk_s = lk_raw_s;
    end else begin : g_nopll
      assign lk_s = 1'b1;
    end
  endgenerate

  assign rdy_w = seq_ready(ext_s, pg_s, lk_s);

  boot_seq_fsm u_fsm (
    .clk       (clk),
    .arst_n    (por_n),
    .ready     (rdy_w),
    .pg_s      (pg_s),
    .bist_done (bist_done),
    .bist_pass (bist_pass),
    .state     (state),
    .ok_flag   (bist_ok_flag),
    .fail_flag (bist_fail_flag)
  );

  boot_seq_stat #(.HAS_PLL(HAS_PLL)) u_stat (
    .lock_s     (lk_raw_s),
    .clk_status (clk_status)
  );

  assign rst_core_n = core_released(state);
  assign bist_start = (state == SQ_BSTART);
  assign run_en     = (state == SQ_RUN);
  assign boot_addr  = '0;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
  input logic clk,
  input logic por_n,
  input logic ext_s,
  input logic pg_s,
  input logic rdy,
  input logic rst_core_n,
  input logic bist_start,
  input logic run_en,
  input logic ok_flag,
  input logic fail_flag
);
  // R1
  ext_low_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
    !ext_s |=> !rst_core_n);

  // R3
  ready_loss_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rdy |=> (!rst_core_n && !run_en));

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    bist_start |=> !bist_start);

  // R4
  start_after_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    bist_start |-> (rst_core_n && $past(rst_core_n)));

  // R5
  run_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(run_en) |-> $past(rst_core_n));

  // R6
  skip_path_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(rst_core_n) && ok_flag) |=> ((run_en || !rst_core_n) && !bist_start));

  // R7
  halt_no_run_chk: assert property (@(posedge clk) disable iff (!por_n)
    fail_flag |-> !run_en);

  // R8
  ok_kept_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ok_flag && pg_s) |=> ok_flag);
endmodule

bind boot_seq boot_seq_chk u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .ext_s      (ext_s),
  .pg_s       (pg_s),
  .rdy        (rdy_w),
  .rst_core_n (rst_core_n),
  .bist_start (bist_start),
  .run_en     (run_en),
  .ok_flag    (bist_ok_flag),
  .fail_flag  (bist_fail_flag)
);

// File: tb/boot_seq_tb.sv
module boot_seq_tb;
  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b0, pwr_good = 1'b0, pll_lock = 1'b0;
  logic bist_done = 1'b0, bist_pass = 1'b0;

  logic        rst_core_n, bist_start, run_en, ok_f, fail_f;
  logic [31:0] boot_addr;
  logic [7:0]  clk_status;
  logic        np_rst_n, np_start, np_run, np_ok, np_fail;
  logic [31:0] np_addr;
  logic [7:0]  np_status;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  boot_seq u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .pwr_good(pwr_good),
    .pll_lock(pll_lock), .bist_done(bist_done), .bist_pass(bist_pass),
    .rst_core_n(rst_core_n), .bist_start(bist_start), .run_en(run_en),
    .boot_addr(boot_addr), .clk_status(clk_status),
    .bist_ok_flag(ok_f), .bist_fail_flag(fail_f)
  );

  boot_seq #(.HAS_PLL(1'b0)) u_nopll (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .pwr_good(pwr_good),
    .pll_lock(1'b0), .bist_done(bist_done), .bist_pass(bist_pass),
    .rst_core_n(np_rst_n), .bist_start(np_start), .run_en(np_run),
    .boot_addr(np_addr), .clk_status(np_status),
    .bist_ok_flag(np_ok), .bist_fail_flag(np_fail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // behavioural reference: phase 0 hold,1 released,2 launch,3 await,4 running,5 halted
  int m_phase = 0, m_ok = 0, m_fail = 0, m_next, m_rdy;
  int ext_hist[2] = '{0, 0};
  int pg_hist[2]  = '{0, 0};
  int lk_hist[2]  = '{0, 0};

  always @(posedge clk) begin
    if (!por_n) begin
      m_phase = 0; m_ok = 0; m_fail = 0;
      ext_hist = '{0, 0}; pg_hist = '{0, 0}; lk_hist = '{0, 0};
    end else begin
      m_rdy  = (ext_hist[1] != 0 && pg_hist[1] != 0 && lk_hist[1] != 0) ? 1 : 0;
      m_next = m_phase;
      if (m_rdy == 0) m_next = 0;
      else if (m_phase == 0) m_next = (m_fail != 0) ? 5 : 1;
      else if (m_phase == 1) m_next = (m_ok != 0) ? 4 : 2;
      else if (m_phase == 2) m_next = 3;
      else if (m_phase == 3 && bist_done) m_next = bist_pass ? 4 : 5;
      if (pg_hist[1] == 0) begin
        m_ok = 0; m_fail = 0;
      end else if (m_phase == 3 && m_rdy != 0 && bist_done) begin
        if (bist_pass) m_ok = 1; else m_fail = 1;
      end
      m_phase = m_next;
      ext_hist[1] = ext_hist[0]; ext_hist[0] = int'(ext_rst_n);
      pg_hist[1]  = pg_hist[0];  pg_hist[0]  = int'(pwr_good);
      lk_hist[1]  = lk_hist[0];  lk_hist[0]  = int'(pll_lock);
    end
  end

  always @(negedge clk) begin
    if ($time > 6) begin
      chk("R1 R2 R3 core reset", 32'(rst_core_n), 32'((m_phase >= 1 && m_phase <= 4) ? 1 : 0));
      chk("R4 self-test launch", 32'(bist_start), 32'((m_phase == 2) ? 1 : 0));
      chk("R5 R6 run enable", 32'(run_en), 32'((m_phase == 4) ? 1 : 0));
      chk("R8 pass flag", 32'(ok_f), 32'(m_ok));
      chk("R7 fail flag", 32'(fail_f), 32'(m_fail));
      chk("R9 boot address", boot_addr, 32'h0);
      chk("R10 clock status", 32'(clk_status), 32'(8'h05 | (lk_hist[1] != 0 ? 8'h02 : 8'h00)));
      chk("R10 no-PLL status", 32'(np_status), 32'h04);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    #1 por_n = 1'b1;
    cyc(2);
    chk("R1 reset state core reset", 32'(rst_core_n), 32'h0);
    chk("R1 reset state run", 32'(run_en), 32'h0);
    // supply and external reset up, lock late
    pwr_good = 1'b1; ext_rst_n = 1'b1; pll_lock = 1'b0;
    cyc(12);
    chk("R2 lock gates release", 32'(rst_core_n), 32'h0);
    chk("R10 no-PLL ignores lock", 32'(np_rst_n), 32'h1);
    pll_lock = 1'b1;
    cyc(6);
    bist_done = 1'b1; bist_pass = 1'b1;
    cyc(1);
    bist_done = 1'b0;
    cyc(4);
    chk("R5 run after pass", 32'(run_en), 32'h1);
    chk("R5 pass flag", 32'(ok_f), 32'h1);
    // verdict strobe outside the await phase
    bist_done = 1'b1; bist_pass = 1'b0;
    cyc(1);
    bist_done = 1'b0;
    cyc(2);
    chk("R5 stray strobe ignored", 32'(fail_f), 32'h0);
    // warm reset through the external pin
    ext_rst_n = 1'b0;
    cyc(5);
    chk("R1 external reset holds core", 32'(rst_core_n), 32'h0);
    ext_rst_n = 1'b1;
    cyc(6);
    chk("R6 skip self-test", 32'(run_en), 32'h1);
    // lock glitch
    pll_lock = 1'b0;
    cyc(5);
    chk("R3 lock loss holds", 32'(rst_core_n), 32'h0);
    chk("R8 lock loss keeps flag", 32'(ok_f), 32'h1);
    pll_lock = 1'b1;
    cyc(6);
    chk("R6 run after relock", 32'(run_en), 32'h1);
    // supply dip clears, then a failing self-test
    pwr_good = 1'b0;
    cyc(5);
    chk("R8 supply loss clears flag", 32'(ok_f), 32'h0);
    pwr_good = 1'b1;
    cyc(6);
    bist_done = 1'b1; bist_pass = 1'b0;
    cyc(1);
    bist_done = 1'b0;
    cyc(3);
    chk("R7 fail flag set", 32'(fail_f), 32'h1);
    chk("R7 halted core reset", 32'(rst_core_n), 32'h0);
    ext_rst_n = 1'b0;
    cyc(4);
    ext_rst_n = 1'b1;
    cyc(8);
    chk("R7 halt survives external reset", 32'(run_en), 32'h0);
    pwr_good = 1'b0;
    cyc(4);
    pwr_good = 1'b1;
    cyc(6);
    bist_done = 1'b1; bist_pass = 1'b1;
    cyc(1);
    bist_done = 1'b0;
    cyc(3);
    chk("R5 run after repower", 32'(run_en), 32'h1);
    #1 por_n = 1'b0;
    cyc(2);
    chk("R8 power-on reset clears flag", 32'(ok_f), 32'h0);
    #1 por_n = 1'b1;
    cyc(10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule